// File: doc/BRIEF.md
# Intra 4x4 Luma Sample Predictor

This block forms the prediction for one 4x4 luma block inside a block-based video decoder. It receives thirteen reconstructed neighbour pixels and one flag each for the upper, left and upper-right neighbours. It also takes a mode number that selects one of nine directional or averaging rules. A single start pulse captures all of these inputs. The block then returns the sixteen predicted pixels as four beats of four pixels each, one beat per row, top row first. A later adder combines each beat with the inverse-transform residue.

The prediction uses a fixed-length pipeline, so the first row appears a known number of cycles after the start, and the remaining rows follow on consecutive cycles. The block handles one prediction at a time. It signals busy from acceptance until the last row has been presented.

Top module: `intra4_pred`

## Requirements
- R1: A block is accepted on a rising clock edge when `start_i` is high and `busy_o` is low. All inputs are captured at that edge, and `busy_o` is high in the following cycle. Changes to `start_i`, `mode_i`, the flags or `nbr_i` while `busy_o` is high change neither the rows being produced nor cause an extra block.
- R2: With the default LATENCY of 4, row 0 is valid right after the third edge following the accept edge. Rows 1, 2 and 3 follow on the next three consecutive cycles. `row_idx_o` carries 0, 1, 2, 3 in that order, and `row_valid_o` is low at all other times.
- R3: `busy_o` stays high through the cycle in which row 3 is shown and is low in the cycle right after. A start in that cycle is accepted.
- R4: Packing. `nbr_i` slot n occupies bits [8n+7:8n]. Slot 0 is the above-left corner M. Slots 1 to 8 are the upper row A to H, left to right. Slots 9 to 12 are the left column I to L, top to bottom. On `row_pix_o`, column x occupies bits [8x+7:8x].
- R5: Mode 0 copies the upper sample of each column into the column. Mode 1 copies the left sample of each row across the row.
- R6: Mode 2 (DC) fills the whole block with one value, chosen by which neighbours are available:
  - both sides available: (A+B+C+D+I+J+K+L+4)>>3
  - upper only: (A+B+C+D+2)>>2
  - left only: (I+J+K+L+2)>>2
  - neither: 128
- R7: Modes 3 (diagonal down-left) and 4 (diagonal down-right) follow the standard 3-tap rounded filter (a+2b+c+2)>>2 along their diagonals.
- R8: Modes 5 (vertical-right) and 6 (horizontal-down) mix the 2-tap filter (a+b+1)>>1 and the 3-tap filter according to the standard zig-zag pattern.
- R9: Modes 7 (vertical-left) and 8 (horizontal-up) follow the standard pattern. In mode 8, samples past the end of the left column take the value L.
- R10: When `tr_avail_i` is low, E, F, G and H are all replaced by D before any mode uses them.
- R11: While reset is applied, and after it is released, `busy_o` and `row_valid_o` are low until a block is accepted.
- R12: Mode codes 9 to 15 produce the same result as mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to predict a block |
| mode_i | input | 4 | Prediction mode number |
| top_avail_i | input | 1 | Upper neighbours A..D available |
| left_avail_i | input | 1 | Left neighbours I..L available |
| tr_avail_i | input | 1 | Upper-right neighbours E..H available |
| nbr_i | input | 104 | Thirteen neighbour pixels, packed as in R4 |
| busy_o | output | 1 | Block in progress; start ignored |
| row_valid_o | output | 1 | A predicted row is present |
| row_idx_o | output | 2 | Row number of the present row |
| row_pix_o | output | 32 | Four predicted pixels of the row |

## Verification
The hardest situation to reach from the ports is one where the inputs change after acceptance. This includes a second start arriving mid-block with a different mode and inverted neighbours: a correct design must ignore it. For every block, the bench inverts `nbr_i` right after the accept edge. In one scenario it also holds `start_i` high with another mode until the last row is shown. It then confirms that the rows match the captured inputs and that no further rows appear. Corner cases in the directional modes include the clamping at L in mode 8 and the G/H corner of mode 3. These are reached with unequal neighbour values, with extremes of 0 and 255, and with the upper-right samples marked unavailable.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  localparam int PIX_W   = 8;
  localparam int NBR_CNT = 13;
  localparam int ROWS    = 4;

  typedef logic [PIX_W-1:0] pix_t;
  // Edge line: [0..3]=L,K,J,I  [4]=corner  [5..12]=A..H
  typedef pix_t [NBR_CNT-1:0] edge_t;
  typedef pix_t [ROWS-1:0]    row_t;

  typedef enum logic [3:0] {
    MD_VERT = 4'd0, MD_HOR = 4'd1, MD_DC = 4'd2, MD_DDL = 4'd3,
    MD_DDR  = 4'd4, MD_VR  = 4'd5, MD_HD = 4'd6, MD_VL  = 4'd7,
    MD_HU   = 4'd8
  } mode_e;

  function automatic int up(edge_t e, int i);   // i = -1 gives the corner
    return int'(e[4'(5 + i)]);
  endfunction

  function automatic int lf(edge_t e, int j);   // j = -1 gives the corner
    return int'(e[4'(3 - j)]);
  endfunction

  function automatic pix_t avg2(int a, int b);
    return pix_t'((a + b + 1) >> 1);
  endfunction

  function automatic pix_t avg3(int a, int b, int c);
    return pix_t'((a + 2 * b + c + 2) >> 2);
  endfunction

  function automatic pix_t pred_sample(edge_t e, pix_t dc, logic [3:0] mode, int x, int y);
    int z;
    pix_t r;
    r = dc;
    case (mode)
      MD_VERT: r = pix_t'(up(e, x));
      MD_HOR:  r = pix_t'(lf(e, y));
      MD_DDL:  r = (x == 3 && y == 3) ? avg3(up(e, 6), up(e, 7), up(e, 7))
                                      : avg3(up(e, x + y), up(e, x + y + 1), up(e, x + y + 2));
      MD_DDR: begin
        if (x > y)      r = avg3(up(e, x - y - 2), up(e, x - y - 1), up(e, x - y));
        else if (x < y) r = avg3(lf(e, y - x - 2), lf(e, y - x - 1), lf(e, y - x));
        else            r = avg3(up(e, 0), up(e, -1), lf(e, 0));
      end
      MD_VR: begin
        z = 2 * x - y;
        if (z >= 0 && z % 2 == 0) r = avg2(up(e, x - (y >> 1) - 1), up(e, x - (y >> 1)));
        else if (z > 0)  r = avg3(up(e, x - (y >> 1) - 2), up(e, x - (y >> 1) - 1), up(e, x - (y >> 1)));
        else if (z == -1) r = avg3(lf(e, 0), lf(e, -1), up(e, 0));
        else             r = avg3(lf(e, y - 1), lf(e, y - 2), lf(e, y - 3));
      end
      MD_HD: begin
        z = 2 * y - x;
        if (z >= 0 && z % 2 == 0) r = avg2(lf(e, y - (x >> 1) - 1), lf(e, y - (x >> 1)));
        else if (z > 0)  r = avg3(lf(e, y - (x >> 1) - 2), lf(e, y - (x >> 1) - 1), lf(e, y - (x >> 1)));
        else if (z == -1) r = avg3(lf(e, 0), lf(e, -1), up(e, 0));
        else             r = avg3(up(e, x - 1), up(e, x - 2), up(e, x - 3));
      end
      MD_VL: begin
        if (y % 2 == 0) r = avg2(up(e, x + (y >> 1)), up(e, x + (y >> 1) + 1));
        else            r = avg3(up(e, x + (y >> 1)), up(e, x + (y >> 1) + 1), up(e, x + (y >> 1) + 2));
      end
      MD_HU: begin
        z = x + 2 * y;
        if (z > 5)           r = pix_t'(lf(e, 3));
        else if (z == 5)     r = avg3(lf(e, 2), lf(e, 3), lf(e, 3));
        else if (z % 2 == 0) r = avg2(lf(e, y + (x >> 1)), lf(e, y + (x >> 1) + 1));
        else                 r = avg3(lf(e, y + (x >> 1)), lf(e, y + (x >> 1) + 1), lf(e, y + (x >> 1) + 2));
      end
      default: r = dc;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/intra4_ref_prep.sv
module intra4_ref_prep
  import intra4_pkg::*;
(
  input  logic [NBR_CNT*PIX_W-1:0] nbr,
  input  logic                     top_av,
  input  logic                     left_av,
  input  logic                     tr_av,
  output edge_t                    edge_o,
  output pix_t                     dc_o
);
  localparam int SUM_W = PIX_W + 4;

  logic [SUM_W-1:0] sum_up, sum_lf;

  generate
    for (genvar n = 0; n < NBR_CNT; n++) begin : g_map
      if (n <= 4) begin : g_up_near
        assign edge_o[4 + n] = nbr[n*PIX_W +: PIX_W];
      end else if (n <= 8) begin : g_up_far
        // upper-right samples fall back to D when not available
        assign edge_o[4 + n] = tr_av ? nbr[n*PIX_W +: PIX_W] : nbr[4*PIX_W +: PIX_W];
      end else begin : g_left
        assign edge_o[12 - n] = nbr[n*PIX_W +: PIX_W];
      end
    end
  endgenerate

  always_comb begin
    sum_up = '0;
    sum_lf = '0;
    for (int k = 1; k <= 4; k++) sum_up = sum_up + SUM_W'(nbr[k*PIX_W +: PIX_W]);
    for (int k = 9; k <= 12; k++) sum_lf = sum_lf + SUM_W'(nbr[k*PIX_W +: PIX_W]);
    case ({top_av, left_av})
      2'b11:   dc_o = pix_t'((sum_up + sum_lf + SUM_W'(4)) >> 3);
      2'b10:   dc_o = pix_t'((sum_up + SUM_W'(2)) >> 2);
      2'b01:   dc_o = pix_t'((sum_lf + SUM_W'(2)) >> 2);
      default: dc_o = pix_t'(1 << (PIX_W - 1));
    endcase
  end
endmodule

// File: rtl/intra4_row_gen.sv
module intra4_row_gen
  import intra4_pkg::*;
(
  input  edge_t      edge_i,
  input  pix_t       dc_i,
  input  logic [3:0] mode_i,
  input  logic [1:0] row_sel,
  output row_t       row_o
);
  generate
    for (genvar x = 0; x < ROWS; x++) begin : g_col
      assign row_o[x] = pred_sample(edge_i, dc_i, mode_i, x, int'(row_sel));
    end
  endgenerate
endmodule

// File: rtl/intra4_pipe.sv
module intra4_pipe
  import intra4_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_v,
  input  logic [1:0] in_idx,
  input  row_t       in_row,
  output logic       out_v,
  output logic [1:0] out_idx,
  output row_t       out_row
);
  logic       v_q   [DEPTH];
  logic [1:0] idx_q [DEPTH];
  row_t       row_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic       v_d, en;
      logic [1:0] idx_d;
      row_t       row_d;
      if (s == 0) begin : g_head
        assign v_d   = in_v;
        assign idx_d = in_idx;
        assign row_d = in_row;
      end else begin : g_body
        assign v_d   = v_q[s-1];
        assign idx_d = idx_q[s-1];
        assign row_d = row_q[s-1];
      end
      assign en = v_d;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q[s] <= 1'b0;
        else        v_q[s] <= v_d;
      end

      always_ff @(posedge clk) begin
        if (en) begin
          idx_q[s] <= idx_d;
          row_q[s] <= row_d;
        end
      end
    end
  endgenerate

  assign out_v   = v_q[DEPTH-1];
  assign out_idx = idx_q[DEPTH-1];
  assign out_row = row_q[DEPTH-1];
endmodule

// File: rtl/intra4_pred.sv
module intra4_pred
  import intra4_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [3:0]               mode_i,
  input  logic                     top_avail_i,
  input  logic                     left_avail_i,
  input  logic                     tr_avail_i,
  input  logic [NBR_CNT*PIX_W-1:0] nbr_i,
  output logic                     busy_o,
  output logic                     row_valid_o,
  output logic [1:0]               row_idx_o,
  output logic [ROWS*PIX_W-1:0]    row_pix_o
);
  localparam int PIPE_DEPTH = LATENCY - 1;
  localparam int LAST_PH    = LATENCY + 2;
  localparam int PH_W       = $clog2(LAST_PH + 1);

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic            busy_q, busy_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            accept, issue_v;

  logic [NBR_CNT*PIX_W-1:0] nbr_q;
  logic [3:0]               mode_q;
  logic                     top_q, left_q, tr_q;

  assign accept  = start_i & ~busy_q;
  assign issue_v = busy_q && (ph_q < PH_W'(ROWS));

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    if (accept) begin
      busy_d = 1'b1;
      ph_d   = '0;
    end else if (busy_q) begin
      ph_d = ph_q + PH_W'(1);
      if (ph_q == PH_W'(LAST_PH)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      nbr_q  <= nbr_i;
      mode_q <= mode_i;
      top_q  <= top_avail_i;
      left_q <= left_avail_i;
      tr_q   <= tr_avail_i;
    end
  end

  edge_t edge_w;
  pix_t  dc_w;
  row_t  row_w, row_out;

  intra4_ref_prep u_prep (
    .nbr     (nbr_q),
    .top_av  (top_q),
    .left_av (left_q),
    .tr_av   (tr_q),
    .edge_o  (edge_w),
    .dc_o    (dc_w)
  );

  intra4_row_gen u_gen (
    .edge_i  (edge_w),
    .dc_i    (dc_w),
    .mode_i  (mode_q),
    .row_sel (ph_q[1:0]),
    .row_o   (row_w)
  );

  intra4_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .in_v    (issue_v),
    .in_idx  (ph_q[1:0]),
    .in_row  (row_w),
    .out_v   (row_valid_o),
    .out_idx (row_idx_o),
    .out_row (row_out)
  );

  assign row_pix_o = row_out;
  assign busy_o    = busy_q;
endmodule

// File: rtl/intra4_pred_chk.sv
module intra4_pred_chk #(
  parameter int LATENCY = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       row_valid_o,
  input logic [1:0] row_idx_o
);
  logic [7:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_q <= 8'hFF;
    else if (start_i && !busy_o)  since_q <= 8'h00;
    else if (since_q != 8'hFF)    since_q <= since_q + 8'h01;
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_row_sequence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_o && row_idx_o != 2'd3) |=> (row_valid_o && row_idx_o == $past(row_idx_o) + 2'd1));

  assert_first_row_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_o && row_idx_o == 2'd0) |-> (since_q == 8'(LATENCY - 1)));

  assert_release_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(row_valid_o && row_idx_o == 2'd3));

  assert_rows_inside_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid_o |-> busy_o);
endmodule

bind intra4_pred intra4_pred_chk #(.LATENCY(LATENCY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .row_valid_o (row_valid_o),
  .row_idx_o   (row_idx_o)
);

// File: tb/intra4_pred_tb.sv
module intra4_pred_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [3:0]   mode_i;
  logic         top_avail_i, left_avail_i, tr_avail_i;
  logic [103:0] nbr_i;
  logic         busy_o, row_valid_o;
  logic [1:0]   row_idx_o;
  logic [31:0]  row_pix_o;

  int n_vec = 0;
  int n_bad = 0;

  int tv [0:8];   // [0]=corner, [1..8]=A..H
  int lv [0:4];   // [0]=corner, [1..4]=I..L
  int dcv;

  always #2 clk = ~clk;

  intra4_pred u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
    .top_avail_i (top_avail_i), .left_avail_i (left_avail_i), .tr_avail_i (tr_avail_i),
    .nbr_i (nbr_i), .busy_o (busy_o), .row_valid_o (row_valid_o),
    .row_idx_o (row_idx_o), .row_pix_o (row_pix_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int tp(int i); return tv[i + 1]; endfunction
  function automatic int lp(int j); return lv[j + 1]; endfunction
  function automatic int a2(int a, int b); return (a + b + 1) / 2; endfunction
  function automatic int a3(int a, int b, int c); return (a + 2 * b + c + 2) / 4; endfunction

  function automatic int ref_px(int md, int x, int y);
    int d;
    case (md)
      0: return tp(x);
      1: return lp(y);
      3: begin
        if (x + y == 6) return a3(tp(6), tp(7), tp(7));
        return a3(tp(x + y), tp(x + y + 1), tp(x + y + 2));
      end
      4: begin
        d = x - y;
        if (d > 0) return a3(tp(d - 2), tp(d - 1), tp(d));
        if (d < 0) return a3(lp(-d - 2), lp(-d - 1), lp(-d));
        return a3(lp(0), tp(-1), tp(0));
      end
      5: begin
        d = 2 * x - y;
        if (d == -1) return a3(tp(0), tp(-1), lp(0));
        if (d < -1)  return a3(lp(y - 3), lp(y - 2), lp(y - 1));
        if (d % 2 == 0) return a2(tp(x - y / 2 - 1), tp(x - y / 2));
        return a3(tp(x - y / 2 - 2), tp(x - y / 2 - 1), tp(x - y / 2));
      end
      6: begin
        d = 2 * y - x;
        if (d == -1) return a3(tp(0), tp(-1), lp(0));
        if (d < -1)  return a3(tp(x - 3), tp(x - 2), tp(x - 1));
        if (d % 2 == 0) return a2(lp(y - x / 2 - 1), lp(y - x / 2));
        return a3(lp(y - x / 2 - 2), lp(y - x / 2 - 1), lp(y - x / 2));
      end
      7: begin
        if (y % 2 == 0) return a2(tp(x + y / 2), tp(x + y / 2 + 1));
        return a3(tp(x + y / 2), tp(x + y / 2 + 1), tp(x + y / 2 + 2));
      end
      8: begin
        d = x + 2 * y;
        if (d > 5)  return lp(3);
        if (d == 5) return a3(lp(2), lp(3), lp(3));
        if (d % 2 == 0) return a2(lp(y + x / 2), lp(y + x / 2 + 1));
        return a3(lp(y + x / 2), lp(y + x / 2 + 1), lp(y + x / 2 + 2));
      end
      default: return dcv;
    endcase
  endfunction

  function automatic logic [103:0] make_nbr(int seed);
    logic [103:0] v;
    for (int n = 0; n < 13; n++) v[n*8 +: 8] = 8'((seed * 37 + n * 53 + (n * n) * seed) ^ (n * 11));
    return v;
  endfunction

  // one prediction, checked beat by beat; poke keeps start high mid-block
  task automatic run_block(input int md, input logic ta, input logic la, input logic tra,
                           input logic [103:0] nb, input string req, input bit poke);
    int su, sl;
    logic [31:0] exp_row;
    tv[0] = int'(nb[7:0]);
    for (int i = 1; i <= 8; i++) tv[i] = int'(nb[i*8 +: 8]);
    if (!tra) for (int i = 5; i <= 8; i++) tv[i] = tv[4];
    lv[0] = tv[0];
    for (int j = 1; j <= 4; j++) lv[j] = int'(nb[(8 + j)*8 +: 8]);
    su = tv[1] + tv[2] + tv[3] + tv[4];
    sl = lv[1] + lv[2] + lv[3] + lv[4];
    if (ta && la) dcv = (su + sl + 4) / 8;
    else if (ta)  dcv = (su + 2) / 4;
    else if (la)  dcv = (sl + 2) / 4;
    else          dcv = 128;

    @(negedge clk);
    start_i = 1'b1; mode_i = 4'(md); top_avail_i = ta; left_avail_i = la;
    tr_avail_i = tra; nbr_i = nb;
    @(posedge clk);
    @(negedge clk);
    start_i = poke; nbr_i = ~nb; mode_i = 4'(md + 3); tr_avail_i = ~tra;
    chk("R1", "busy after accept", 32'(busy_o), 32'd1);
    chk("R2", "no row at accept+1", 32'(row_valid_o), 32'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R2", "no early row", 32'(row_valid_o), 32'd0);
    end
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      for (int x = 0; x < 4; x++) exp_row[x*8 +: 8] = 8'(ref_px(md, x, r));
      chk("R2", $sformatf("valid row %0d", r), 32'(row_valid_o), 32'd1);
      chk("R2", $sformatf("index row %0d", r), 32'(row_idx_o), 32'(r));
      chk(req, $sformatf("R4 mode %0d row %0d pixels", md, r), row_pix_o, exp_row);
      chk("R3", $sformatf("busy at row %0d", r), 32'(busy_o), 32'd1);
    end
    start_i = 1'b0;
    @(negedge clk);
    chk("R3", "busy released", 32'(busy_o), 32'd0);
    chk("R2", "no row after last", 32'(row_valid_o), 32'd0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R1", "no phantom block", {30'd0, busy_o, row_valid_o}, 32'd0);
      end
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 4'd0;
    top_avail_i = 1'b0; left_avail_i = 1'b0; tr_avail_i = 1'b0; nbr_i = '0;
    repeat (3) @(negedge clk);
    chk("R11", "busy in reset", 32'(busy_o), 32'd0);
    chk("R11", "valid in reset", 32'(row_valid_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "busy after reset", 32'(busy_o), 32'd0);
    chk("R11", "valid after reset", 32'(row_valid_o), 32'd0);
  endtask

  task automatic test_copy_modes;   // R5
    run_block(0, 1'b1, 1'b1, 1'b1, make_nbr(3), "R5", 1'b0);
    run_block(1, 1'b1, 1'b1, 1'b1, make_nbr(5), "R5", 1'b0);
  endtask

  task automatic test_dc;           // R6
    run_block(2, 1'b1, 1'b1, 1'b1, make_nbr(7), "R6", 1'b0);
    run_block(2, 1'b1, 1'b0, 1'b1, make_nbr(9), "R6", 1'b0);
    run_block(2, 1'b0, 1'b1, 1'b0, make_nbr(11), "R6", 1'b0);
    run_block(2, 1'b0, 1'b0, 1'b0, make_nbr(13), "R6", 1'b0);
  endtask

  task automatic test_directional;  // R7 R8 R9
    logic [103:0] ext;
    for (int n = 0; n < 13; n++) ext[n*8 +: 8] = (n % 3 == 0) ? 8'hFF : ((n % 3 == 1) ? 8'h00 : 8'h81);
    run_block(3, 1'b1, 1'b1, 1'b1, make_nbr(17), "R7", 1'b0);
    run_block(4, 1'b1, 1'b1, 1'b1, make_nbr(19), "R7", 1'b0);
    run_block(5, 1'b1, 1'b1, 1'b1, make_nbr(23), "R8", 1'b0);
    run_block(6, 1'b1, 1'b1, 1'b1, make_nbr(29), "R8", 1'b0);
    run_block(6, 1'b1, 1'b1, 1'b1, ext, "R8", 1'b0);
    run_block(7, 1'b1, 1'b1, 1'b1, make_nbr(31), "R9", 1'b0);
    run_block(8, 1'b1, 1'b1, 1'b1, make_nbr(37), "R9", 1'b0);
    run_block(8, 1'b1, 1'b1, 1'b1, ext, "R9", 1'b0);
  endtask

  task automatic test_topright;     // R10
    run_block(3, 1'b1, 1'b1, 1'b0, make_nbr(41), "R10", 1'b0);
    run_block(7, 1'b1, 1'b1, 1'b0, make_nbr(43), "R10", 1'b0);
  endtask

  task automatic test_reserved;     // R12
    run_block(12, 1'b1, 1'b1, 1'b1, make_nbr(47), "R12", 1'b0);
    run_block(15, 1'b0, 1'b1, 1'b1, make_nbr(53), "R12", 1'b0);
  endtask

  task automatic test_busy_ignore;  // R1
    run_block(4, 1'b1, 1'b1, 1'b1, make_nbr(59), "R1", 1'b1);
  endtask

  initial begin
    test_reset();
    test_copy_modes();
    test_dc();
    test_directional();
    test_topright();
    test_reserved();
    test_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule